// File: doc/BRIEF.md
# Serial audio sample transmitter

This block turns parallel audio samples into a single serial data line framed by an external word-select signal. A separate framing stage supplies a one-cycle strobe for each bit period (marking the bit-clock edge on which data changes) together with the word-select level. Software or a data mover places 32-bit words into a one-deep holding register. The block then sends each sample MSB first in the left slot (word-select low) or the right slot (word-select high).

A 3-bit length code sets the sample size. Two codes pack two short samples into one word. A mono switch sends every left sample a second time in the right slot. When a slot begins with no word waiting, the block raises a sticky underrun flag and fills the slot with zeros, or with the last sample of that channel when the repeat option is set. Start and stop command pulses take effect only at the start of a left slot, so frames are never cut in half. A 2-bit format code chooses standard I2S timing or left-justified timing. Slot length comes entirely from the word-select period that the framing stage produces.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset the data line is low, the ready flag is high and the underrun flag is low.
- R2: A write while ready is high loads the holding register and drops ready on the next clock. Ready stays low until a slot start consumes the word. A write while ready is low is ignored, and the held word is not changed.
- R3: Word-select low marks the left slot and high marks the right slot. With format 1 (left-justified), the MSB is sent in the bit period where word-select changes. With format 0 (standard I2S), the MSB is sent one bit period later.
- R4: Samples are sent MSB first, taken from the low bits of the word. The sample length depends on the length code: 0 gives 32 bits, 1 gives 24, 2 gives 20, 3 gives 18, 4 gives 16 and 6 gives 8. Every slot bit after the last sample bit is low.
- R5: Length code 5 packs two 16-bit samples per word: bits 15:0 go to the left slot and bits 31:16 to the right slot. Length code 7 packs two 8-bit samples per word: bits 7:0 go left and bits 15:8 go right. Each frame consumes one word.
- R6: With mono set, the right slot repeats the sample sent in the left slot, and each frame consumes one word.
- R7: While transmission is active, if a slot that needs a new word starts with the holding register empty, the underrun flag sets and stays set until a start pulse clears it. With the repeat option clear, that slot carries all zeros.
- R8: With the repeat option set, a slot that underruns carries the last sample that was sent on the same channel.
- R9: Start and stop pulses change the running state only at the next left-slot start. Inactive slots keep the data line low. A stop pulse in the middle of a left slot still lets the right slot of that frame go out. If both pulses arrive in the same cycle, stop wins.
- R10: With format code 2 or 3, the data line stays low and no word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-clock data edge |
| ws | input | 1 | Word select, sampled on bit_tick (0 left, 1 right) |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 32 | Holding-register write data |
| len_code | input | 3 | Sample length code |
| fmt | input | 2 | Framing code: 0 I2S, 1 left-justified, 2/3 reserved |
| mono | input | 1 | Send left sample in both slots |
| repeat_last | input | 1 | Underrun fill: 0 zeros, 1 last sample |
| tx_start | input | 1 | Start command pulse |
| tx_stop | input | 1 | Stop command pulse |
| sdo | output | 1 | Serial data line |
| ready | output | 1 | Holding register can take a word |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Each new data bit appears on `sdo` at the same clock edge that samples `bit_tick`. The bench therefore reads the line on the falling clock edge right after each strobe. It rebuilds the slot boundary from word-select on its own: the change tick for left-justified framing, one tick later for standard I2S. Ready falls one clock after an accepted write and rises at the clock edge of the consuming tick. The underrun flag sets at that same edge. Start and stop show up only in the first slot that begins after the next falling edge of word-select, so each expected slot word is queued in frame order. The bench compares each slot once all 32 of its bits have arrived. Flag checks are made only between frames, when no tick is pending.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        ws,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [2:0]  len_code,
  input  logic [1:0]  fmt,
  input  logic        mono,
  input  logic        repeat_last,
  input  logic        tx_start,
  input  logic        tx_stop,
  output logic        sdo,
  output logic        ready,
  output logic        underrun
);
  localparam int SW = 32;
  localparam int LW = $clog2(SW) + 1;

  logic [SW-1:0] hr, sh, prev_l, prev_r, la, ra, sel;
  logic [LW-1:0] len;
  logic full, active, run_req, under_q, ws_q, chg_d, ch_d, r_zero, sdo_q;
  logic pack16, pack8, shared, fmt_ok, lj, chg, start, chan, left_st;
  logic act_n, fetch, take, miss;

  always_comb begin
    case (len_code)
      3'd0:         len = LW'(SW);
      3'd1:         len = LW'(24);
      3'd2:         len = LW'(20);
      3'd3:         len = LW'(18);
      3'd4, 3'd5:   len = LW'(16);
      default:      len = LW'(8);
    endcase
  end

  assign pack16  = (len_code == 3'd5);
  assign pack8   = (len_code == 3'd7);
  assign shared  = pack16 | pack8 | mono;
  assign fmt_ok  = ~fmt[1];
  assign lj      = fmt[0];

  assign chg     = ws ^ ws_q;
  assign start   = bit_tick & fmt_ok & (lj ? chg : chg_d);
  assign chan    = lj ? ws : ch_d;
  assign left_st = start & ~chan;
  assign act_n   = left_st ? run_req : active;
  assign fetch   = start & act_n & (~chan | ~shared);
  assign take    = fetch & full;
  assign miss    = fetch & ~full;

  always_comb begin
    la = hr << (LW'(SW) - len);
    ra = la;
    if (pack16) begin
      la = {hr[15:0], 16'h0};
      ra = {hr[31:16], 16'h0};
    end else if (pack8) begin
      la = {hr[7:0], 24'h0};
      ra = {hr[15:8], 24'h0};
    end
  end

  always_comb begin
    if (!act_n)       sel = '0;
    else if (!chan)   sel = take ? la : (repeat_last ? prev_l : '0);
    else if (shared)  sel = r_zero ? '0 : prev_r;
    else              sel = take ? la : (repeat_last ? prev_r : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr      <= '0;
      sh      <= '0;
      prev_l  <= '0;
      prev_r  <= '0;
      full    <= 1'b0;
      active  <= 1'b0;
      run_req <= 1'b0;
      under_q <= 1'b0;
      ws_q    <= 1'b0;
      chg_d   <= 1'b0;
      ch_d    <= 1'b0;
      r_zero  <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      if (bit_tick) begin
        ws_q  <= ws;
        chg_d <= chg;
        ch_d  <= ws;
        sdo_q <= fmt_ok & (start ? sel[SW-1] : sh[SW-1]);
        sh    <= start ? (sel << 1) : (sh << 1);
      end
      if (left_st) begin
        active <= run_req;
        r_zero <= ~take & ~repeat_last;
      end
      if (take && !chan) begin
        prev_l <= la;
        if (shared) prev_r <= ra;
      end
      if (take && chan) prev_r <= la;

      if (tx_stop)       run_req <= 1'b0;
      else if (tx_start) run_req <= 1'b1;

      if (tx_start)      under_q <= 1'b0;
      else if (miss)     under_q <= 1'b1;

      if (take)          full <= 1'b0;
      else if (wr_en)    full <= 1'b1;
      if (wr_en && !full) hr <= wr_data;
    end
  end

  assign sdo      = sdo_q;
  assign ready    = ~full;
  assign underrun = under_q;
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       wr_en,
  input logic       tx_start,
  input logic [1:0] fmt,
  input logic       active,
  input logic       sdo,
  input logic       ready,
  input logic       underrun
);
  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> (!sdo && ready && !underrun)); // R1
  AST_FILL_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n) (ready && wr_en) |=> !ready); // R2
  AST_READY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |-> $past(wr_en)); // R2
  AST_READY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> $past(bit_tick)); // R2
  AST_UNDERRUN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(underrun) |-> $past(bit_tick)); // R7
  AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) tx_start |=> !underrun); // R7
  AST_RUN_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$stable(active) |-> $past(bit_tick)); // R9
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n) ($past(fmt[1]) && $past(bit_tick)) |-> !sdo); // R10
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .tx_start(tx_start),
  .fmt(fmt), .active(active), .sdo(sdo), .ready(ready), .underrun(underrun)
);

// File: tb/sim_i2s_tx_serializer.sv
`timescale 1ns/1ps
module sim_i2s_tx_serializer;
  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, ws = 1'b1, wr_en = 1'b0;
  logic mono = 1'b0, repeat_last = 1'b0, tx_start = 1'b0, tx_stop = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  len_code = '0;
  logic [1:0]  fmt = '0;
  logic sdo, ready, underrun;

  always #4 clk = ~clk;

  i2s_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ws(ws), .wr_en(wr_en), .wr_data(wr_data),
    .len_code(len_code), .fmt(fmt), .mono(mono), .repeat_last(repeat_last),
    .tx_start(tx_start), .tx_stop(tx_stop), .sdo(sdo), .ready(ready), .underrun(underrun)
  );

  typedef struct { logic [31:0] v; string r; } exp_t;
  typedef struct { logic [31:0] d; bit f; } fd_t;
  exp_t eq[$];
  fd_t  fq[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // feeder: writes queued words when ready (forced items write regardless)
  initial forever begin
    @(negedge clk);
    if (rst_n && fq.size() > 0 && (ready || fq[0].f)) begin
      wr_en = 1'b1;
      wr_data = fq[0].d;
      void'(fq.pop_front());
    end else begin
      wr_en = 1'b0;
    end
  end

  // monitor: rebuilds slots from word select and scores them
  logic m_wsq = 1'b0, m_chgd = 1'b0, m_ws, m_chg, m_st;
  bit m_in = 1'b0;
  int m_cnt = 0;
  logic [31:0] m_w = '0;
  exp_t m_e;
  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      m_wsq = 1'b0; m_chgd = 1'b0; m_in = 1'b0; m_cnt = 0;
    end else if (bit_tick) begin
      m_ws  = ws;
      m_chg = m_ws ^ m_wsq;
      m_st  = (fmt == 2'b01) ? m_chg : m_chgd;
      m_chgd = m_chg;
      m_wsq  = m_ws;
      @(negedge clk);
      if (m_st) begin m_in = 1'b1; m_cnt = 0; m_w = '0; end
      if (m_in) begin
        m_w = {m_w[30:0], sdo};
        m_cnt++;
        if (m_cnt == 32) begin
          m_in = 1'b0;
          if (eq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R3 unexpected slot actual=%h expected=none", m_w);
          end else begin
            m_e = eq.pop_front();
            chk(m_e.r, m_w, m_e.v);
          end
        end
      end
    end
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input logic w, input bit stp);
    @(negedge clk); ws = w; bit_tick = 1'b1; tx_stop = stp;
    @(negedge clk); bit_tick = 1'b0; tx_stop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] v, input string r);
    exp_t e; e.v = v; e.r = r; eq.push_back(e);
  endtask

  task automatic feed(input logic [31:0] d, input bit f);
    fd_t x; x.d = d; x.f = f; fq.push_back(x);
  endtask

  task automatic frame(input logic [31:0] l, input logic [31:0] r, input string tg, input bit smid);
    put(l, tg); put(r, tg);
    for (int i = 0; i < 32; i++) tick(1'b0, smid && i == 16);
    for (int i = 0; i < 32; i++) tick(1'b1, 1'b0);
  endtask

  task automatic setup(input logic [1:0] f, input logic [2:0] lc, input logic mn, input logic rp);
    rst_n = 1'b0; bit_tick = 1'b0; ws = 1'b1; tx_start = 1'b0; tx_stop = 1'b0;
    eq.delete(); fq.delete();
    repeat (3) @(negedge clk);
    fmt = f; len_code = lc; mono = mn; repeat_last = rp;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go();
    repeat (4) @(negedge clk);
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    put('0, "R9");
    for (int i = 0; i < 32; i++) tick(1'b1, 1'b0);
  endtask

  task automatic wrap();
    @(negedge clk); tx_stop = 1'b1; @(negedge clk); tx_stop = 1'b0;
    frame('0, '0, "R9", 1'b0);
    frame('0, '0, "R9", 1'b0);
    tick(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R3 slots left", 32'(eq.size()), 32'd0);
  endtask

  function automatic logic [31:0] al(input logic [31:0] w, input int n);
    return (n == 32) ? w : (w << (32 - n));
  endfunction

  initial begin
    // reset state
    setup(2'b01, 3'd0, 1'b0, 1'b0);
    chk("R1 sdo", 32'(sdo), 32'd0);
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 underrun", 32'(underrun), 32'd0);

    // left-justified, 32-bit stereo
    feed(32'hA5C30F81, 0); feed(32'h12345678, 0); feed(32'h80000001, 0); feed(32'hFFFF0000, 0);
    go();
    frame(32'hA5C30F81, 32'h12345678, "R3/R4 lj32", 1'b0);
    frame(32'h80000001, 32'hFFFF0000, "R3/R4 lj32", 1'b0);
    chk("R7 no underrun", 32'(underrun), 32'd0);
    chk("R2 ready after drain", 32'(ready), 32'd1);
    wrap();

    // standard I2S, 24-bit, upper bits discarded
    setup(2'b00, 3'd1, 1'b0, 1'b0);
    feed(32'hFF123456, 0); feed(32'h00ABCDEF, 0); feed(32'h7F800001, 0); feed(32'h00800000, 0);
    repeat (3) @(negedge clk);
    chk("R2 ready low when held", 32'(ready), 32'd0);
    go();
    frame(al(32'hFF123456, 24), al(32'h00ABCDEF, 24), "R3/R4 i2s24", 1'b0);
    frame(al(32'h7F800001, 24), al(32'h00800000, 24), "R3/R4 i2s24", 1'b0);
    wrap();

    // packed 16
    setup(2'b00, 3'd5, 1'b0, 1'b0);
    feed(32'hBEEF1234, 0); feed(32'h00018000, 0);
    go();
    frame(32'h12340000, 32'hBEEF0000, "R5 pack16", 1'b0);
    frame(32'h80000000, 32'h00010000, "R5 pack16", 1'b0);
    chk("R5 no underrun", 32'(underrun), 32'd0);
    wrap();

    // packed 8, left-justified
    setup(2'b01, 3'd7, 1'b0, 1'b0);
    feed(32'h5A5AC37E, 0);
    go();
    frame(32'h7E000000, 32'hC3000000, "R5 pack8", 1'b0);
    wrap();

    // mono, 20-bit
    setup(2'b00, 3'd2, 1'b1, 1'b0);
    feed(32'hFFF81234, 0); feed(32'h00040001, 0);
    go();
    frame(al(32'hFFF81234, 20), al(32'hFFF81234, 20), "R6 mono20", 1'b0);
    frame(al(32'h00040001, 20), al(32'h00040001, 20), "R6 mono20", 1'b0);
    chk("R6 no underrun", 32'(underrun), 32'd0);
    wrap();

    // underrun with zero fill, 18-bit
    setup(2'b00, 3'd3, 1'b0, 1'b0);
    feed(32'h00030005, 0);
    go();
    frame(al(32'h00030005, 18), '0, "R7 zero fill", 1'b0);
    frame('0, '0, "R7 zero fill", 1'b0);
    chk("R7 flag set", 32'(underrun), 32'd1);
    @(negedge clk); tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    @(negedge clk);
    chk("R7 start clears flag", 32'(underrun), 32'd0);
    wrap();

    // underrun with repeat, 16-bit
    setup(2'b01, 3'd4, 1'b0, 1'b1);
    feed(32'h0000ABCD, 0); feed(32'hFFFF1357, 0);
    go();
    frame(32'hABCD0000, 32'h13570000, "R8 repeat", 1'b0);
    frame(32'hABCD0000, 32'h13570000, "R8 repeat", 1'b0);
    chk("R8 flag set", 32'(underrun), 32'd1);
    wrap();

    // stop in the middle of a left slot
    setup(2'b01, 3'd0, 1'b0, 1'b0);
    feed(32'hDEADBEEF, 0); feed(32'h0BADF00D, 0); feed(32'hCAFEF00D, 0);
    go();
    frame(32'hDEADBEEF, 32'h0BADF00D, "R9 stop mid", 1'b1);
    frame('0, '0, "R9 stopped", 1'b0);
    chk("R9 no fetch when stopped", 32'(ready), 32'd0);
    wrap();

    // write while full ignored
    setup(2'b01, 3'd0, 1'b0, 1'b0);
    feed(32'h11111111, 0); feed(32'h22222222, 1);
    repeat (4) @(negedge clk);
    chk("R2 ready after write", 32'(ready), 32'd0);
    go();
    frame(32'h11111111, '0, "R2 ignored write", 1'b0);
    chk("R7 flag after miss", 32'(underrun), 32'd1);
    wrap();

    // reserved framing code
    setup(2'b10, 3'd0, 1'b0, 1'b0);
    feed(32'hFFFFFFFF, 0);
    go();
    frame('0, '0, "R10 reserved", 1'b0);
    frame('0, '0, "R10 reserved", 1'b0);
    chk("R10 word kept", 32'(ready), 32'd0);
    wrap();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule